// File: doc/BRIEF.md
# Serial Receive Queue

This block is the receive half of one asynchronous serial channel. A free-running enable pulse at sixteen times the bit rate paces it. It watches an idle-high line for a falling edge and confirms that edge half a bit later. It then samples each data bit, the optional parity bit and the stop bit at the centre of its bit period. Each finished character goes into a small queue together with its own parity, framing and overrun flags.

The host reads the queue through a pop strobe. The head entry stays on the read outputs for as long as the queue is not empty. A programmable fill threshold drives a ready flag. A flush strobe empties the queue and aborts any character being received. A level enable stops reception altogether.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty: `rd_valid` and `fill` are 0, and `rx_ready` is 0 whenever `trig_lvl` is nonzero.
- R2: Data bits are received least significant bit first. `char_len` sets the character length: 0 for 5 bits, 1 for 6, 2 for 7 and 3 for 8. Bits of `rd_data` above the character length read as zero.
- R3: A low level on the line starts a character only if the line is still low at the eighth 16x tick after the low was first seen. A shorter low pulse is ignored and stores nothing.
- R4: Once the start is confirmed, every data, parity and stop bit is sampled once, 16 ticks after the previous sample, so disturbances near bit edges do not change the received value.
- R5: With `par_en` set, a parity bit follows the data. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. A mismatch sets `rd_perr` on that entry. With `par_en` clear, `rd_perr` is 0.
- R6: A stop bit sampled low sets `rd_ferr` on that entry. The character is still stored.
- R7: Entries are read in arrival order. `pop` removes the head while `rd_valid` is 1. `fill` gives the number of stored entries, up to DEPTH.
- R8: A character that completes while the queue is full, with no pop in the same cycle, is dropped, and `rd_ovr` is set on the most recently stored entry. Entries stored later carry `rd_ovr`=0.
- R9: A one-cycle `rx_flush` empties the queue, discards all stored error flags and returns the line sampler to idle.
- R10: `rx_ready` is 1 exactly when `fill` is greater than or equal to `trig_lvl`.
- R11: While `rx_en` is 0, no character is received and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| rx_flush | input | 1 | Flush queue and abort reception |
| char_len | input | 2 | Character length code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 for odd parity, 0 for even |
| trig_lvl | input | $clog2(DEPTH+1) | Fill threshold for `rx_ready` |
| serial_in | input | 1 | Serial line, idle high |
| pop | input | 1 | Remove head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_ovr | output | 1 | Overrun followed the head entry |
| fill | output | $clog2(DEPTH+1) | Number of stored entries |
| rx_ready | output | 1 | Fill at or above threshold |

## Verification
Some properties are checked on every cycle: the fill never exceeds the depth, a flush empties the queue, a pop that is not paired with a write lowers the fill by one, a dropped character leaves the fill unchanged, a completed character raises a single-cycle strobe, and a disabled receiver returns to idle. Other behaviour shows only at the ports and is covered by the bench scenarios. These scenarios cover bit order, masking of short characters, parity sense, framing, start-noise rejection, resistance to disturbances near bit edges, and placement of the overrun mark on the right entry.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [BYTE_W-1:0] data;
  } rxq_entry_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } rxq_state_t;
endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       flush,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       serial_in,
  output logic       done,
  output rxq_entry_t word
);
  logic [1:0]        sync_q;
  logic              line;
  rxq_state_t        st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [2:0]        idx_q, idx_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              done_q, done_d;
  rxq_entry_t        word_q, word_d;
  logic [BYTE_W-1:0] aligned;
  logic              last_bit;

  assign line     = sync_q[1];
  assign aligned  = sh_q >> (2'd3 - char_len);
  assign last_bit = (idx_q == ({1'b0, char_len} + 3'd4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], serial_in};
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pbit_d = pbit_q;
    done_d = 1'b0;
    word_d = word_q;
    if (!enable || flush) begin
      st_d  = S_IDLE;
      cnt_d = '0;
    end else if (tick) begin
      unique case (st_q)
        S_IDLE: begin
          if (!line) begin
            st_d  = S_START;
            cnt_d = '0;
          end
        end
        S_START: begin
          if (cnt_q == 4'd7) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = line ? S_IDLE : S_DATA;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        S_DATA: begin
          if (cnt_q == 4'd15) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[BYTE_W-1:1]};
            if (last_bit) st_d = par_en ? S_PAR : S_STOP;
            else          idx_d = idx_q + 3'd1;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        S_PAR: begin
          if (cnt_q == 4'd15) begin
            cnt_d  = '0;
            pbit_d = line;
            st_d   = S_STOP;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        S_STOP: begin
          if (cnt_q == 4'd15) begin
            cnt_d       = '0;
            st_d        = S_IDLE;
            done_d      = 1'b1;
            word_d.data = aligned;
            word_d.perr = par_en & (^aligned ^ pbit_q ^ par_odd);
            word_d.ferr = ~line;
            word_d.ovr  = 1'b0;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pbit_q <= pbit_d;
      done_q <= done_d;
      word_q <= word_d;
    end
  end

  assign done = done_q;
  assign word = word_q;

  // R2
  smp_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R11
  smp_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == S_IDLE));
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  rxq_entry_t    wr_word,
  input  logic          pop,
  output logic          rd_valid,
  output rxq_entry_t    rd_word,
  output logic [CW-1:0] count
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          full, empty;
  logic          do_pop, do_push, mark_ovr;

  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign do_pop   = pop && !empty && !flush;
  assign do_push  = push && !flush && (!full || do_pop);
  assign mark_ovr = push && !flush && full && !do_pop;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_d = rd_ptr_q + AW'(1);
      count_d = count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)       mem[wr_ptr_q] <= wr_word;
    else if (mark_ovr) mem[wr_ptr_q - AW'(1)].ovr <= 1'b1;
  end

  assign rd_valid = !empty;
  assign rd_word  = empty ? '0 : mem[rd_ptr_q];
  assign count    = count_q;

  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  // R9
  fifo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0));

  // R7
  fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push && !flush) |=> (count_q == $past(count_q) - CW'(1)));

  // R8
  fifo_drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          rx_flush,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [CW-1:0] trig_lvl,
  input  logic          serial_in,
  input  logic          pop,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_ovr,
  output logic [CW-1:0] fill,
  output logic          rx_ready
);
  logic       smp_done;
  rxq_entry_t smp_word;
  rxq_entry_t head;

  rxq_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .enable    (rx_en),
    .flush     (rx_flush),
    .char_len  (char_len),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .serial_in (serial_in),
    .done      (smp_done),
    .word      (smp_word)
  );

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (rx_flush),
    .push     (smp_done),
    .wr_word  (smp_word),
    .pop      (pop),
    .rd_valid (rd_valid),
    .rd_word  (head),
    .count    (fill)
  );

  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rd_ovr   = head.ovr;
  assign rx_ready = (fill >= trig_lvl);

  // R1
  top_empty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> !rd_valid);
endmodule

// File: tb/tb_rxq_top.sv
module tb_rxq_top;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk, rst_n, tick16, rx_en, rx_flush, par_en, par_odd, serial_in, pop;
  logic [1:0]    char_len;
  logic [CW-1:0] trig_lvl, fill;
  logic          rd_valid, rd_perr, rd_ferr, rd_ovr, rx_ready;
  logic [7:0]    rd_data;

  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
    logic       ov;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  bit   mon_en = 0;
  int   tdiv  = 0;

  rxq_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rx_flush(rx_flush),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .trig_lvl(trig_lvl),
    .serial_in(serial_in), .pop(pop), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_ovr(rd_ovr), .fill(fill), .rx_ready(rx_ready)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  initial begin
    tick16 = 0;
    forever begin
      @(negedge clk);
      tdiv   = (tdiv + 1) % 4;
      tick16 = (tdiv == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops entries and compares with the scoreboard queue
  initial begin
    pop = 0;
    forever begin
      @(negedge clk);
      if (pop) pop = 0;
      else if (mon_en && rd_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected entry", rd_data, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rd_data == e.d, e.req, "data", rd_data, e.d);
          check({rd_perr, rd_ferr, rd_ovr} == {e.pe, e.fe, e.ov}, e.req,
                "flags perr/ferr/ovr", {rd_perr, rd_ferr, rd_ovr}, {e.pe, e.fe, e.ov});
        end
        pop = 1;
      end
    end
  end

  // driver: sends one character and pushes its expected entry
  task automatic send_char(input logic [7:0] d, input bit glitch, input bit flip_par,
                           input bit bad_stop, input bit keep, input string req);
    int         n;
    logic [7:0] masked;
    logic       pb;
    exp_t       e;
    n      = 5 + int'(char_len);
    masked = d & 8'((1 << n) - 1);
    pb     = (^masked) ^ par_odd ^ flip_par;
    if (keep) begin
      e.d = masked; e.pe = par_en & flip_par; e.fe = bad_stop; e.ov = 0; e.req = req;
      exp_q.push_back(e);
    end
    serial_in = 0;
    repeat (64) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (glitch) begin
        serial_in = ~d[i];
        repeat (16) @(negedge clk);
        serial_in = d[i];
        repeat (48) @(negedge clk);
      end else begin
        serial_in = d[i];
        repeat (64) @(negedge clk);
      end
    end
    if (par_en) begin
      serial_in = pb;
      repeat (64) @(negedge clk);
    end
    if (bad_stop) begin
      serial_in = 0;
      repeat (48) @(negedge clk);
      serial_in = 1;
      repeat (64) @(negedge clk);
    end else begin
      serial_in = 1;
      repeat (64) @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic wait_drain(input string req);
    int w = 0;
    while (exp_q.size() != 0 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; rx_en = 1; rx_flush = 0; char_len = 2'd3; par_en = 0; par_odd = 0;
    trig_lvl = CW'(1); serial_in = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(rd_valid == 0, "R1", "rd_valid after reset", rd_valid, 0);
    check(fill == 0, "R1", "fill after reset", fill, 0);
    check(rx_ready == 0, "R1", "rx_ready after reset", rx_ready, 0);

    // R2 R7: 8-bit characters, order preserved
    mon_en = 1;
    send_char(8'hA5, 0, 0, 0, 1, "R2");
    send_char(8'h3C, 0, 0, 0, 1, "R7");
    send_char(8'h01, 0, 0, 0, 1, "R2");
    wait_drain("R7");

    // R2 short characters: unused high bits zero
    char_len = 2'd0; send_char(8'hFF, 0, 0, 0, 1, "R2");
    char_len = 2'd1; send_char(8'hEA, 0, 0, 0, 1, "R2");
    char_len = 2'd2; send_char(8'hD5, 0, 0, 0, 1, "R2");
    char_len = 2'd3;
    wait_drain("R2");

    // R5 parity even/odd, good and bad
    par_en = 1; par_odd = 0;
    send_char(8'h96, 0, 0, 0, 1, "R5");
    send_char(8'h97, 0, 1, 0, 1, "R5");
    par_odd = 1;
    send_char(8'h5A, 0, 0, 0, 1, "R5");
    send_char(8'h5B, 0, 1, 0, 1, "R5");
    par_en = 0; par_odd = 0;
    wait_drain("R5");

    // R6 framing error
    send_char(8'h42, 0, 0, 1, 1, "R6");
    send_char(8'h24, 0, 0, 0, 1, "R6");
    wait_drain("R6");

    // R3 short low pulse ignored
    serial_in = 0;
    repeat (12) @(negedge clk);
    serial_in = 1;
    repeat (200) @(negedge clk);
    check(fill == 0, "R3", "fill after noise pulse", fill, 0);
    check(rd_valid == 0, "R3", "rd_valid after noise pulse", rd_valid, 0);

    // R4 disturbances at bit edges do not change sampled bits
    send_char(8'hC3, 1, 0, 0, 1, "R4");
    send_char(8'h5E, 1, 0, 0, 1, "R4");
    wait_drain("R4");

    // R10 threshold, R9 flush
    mon_en = 0; trig_lvl = CW'(3);
    par_en = 1;
    send_char(8'h11, 0, 1, 0, 1, "R9");
    send_char(8'h22, 0, 0, 1, 1, "R9");
    check(rx_ready == 0, "R10", "rx_ready below threshold", rx_ready, 0);
    send_char(8'h33, 0, 0, 0, 1, "R10");
    check(rx_ready == 1, "R10", "rx_ready at threshold", rx_ready, 1);
    check(fill == 3, "R7", "fill count", fill, 3);
    rx_flush = 1;
    @(negedge clk);
    rx_flush = 0;
    @(negedge clk);
    exp_q.delete();
    check(fill == 0, "R9", "fill after flush", fill, 0);
    check(rd_valid == 0, "R9", "rd_valid after flush", rd_valid, 0);
    check(rx_ready == 0, "R9", "rx_ready after flush", rx_ready, 0);
    par_en = 0; trig_lvl = CW'(1);
    mon_en = 1;
    send_char(8'h77, 0, 0, 0, 1, "R9");
    wait_drain("R9");

    // R8 overrun
    mon_en = 0;
    for (int i = 0; i < DEPTH; i++) send_char(8'(8'h80 + i), 0, 0, 0, 1, "R8");
    send_char(8'hEE, 0, 0, 0, 0, "R8");
    send_char(8'hDD, 0, 0, 0, 0, "R8");
    check(fill == DEPTH, "R8", "fill when full", fill, DEPTH);
    exp_q[exp_q.size() - 1].ov = 1;
    mon_en = 1;
    wait_drain("R8");
    send_char(8'h6B, 0, 0, 0, 1, "R8");
    wait_drain("R8");

    // R11 receiver disabled
    rx_en = 0;
    send_char(8'h99, 0, 0, 0, 0, "R11");
    repeat (20) @(negedge clk);
    check(fill == 0, "R11", "fill while disabled", fill, 0);
    rx_en = 1;
    repeat (20) @(negedge clk);
    send_char(8'h5C, 0, 0, 0, 1, "R11");
    wait_drain("R11");

    finish_run();
  end
endmodule